// File: doc/BRIEF.md
# Exception Link Register Access Controller

This block holds the two 64-bit exception link registers of a core: one for the first privileged level (EL1) and one for the hypervisor level (EL2). It receives system-register read and write requests, each tagged with its five-field encoding and the requester's current exception level. In the same cycle it decides what the request turns into. The outcome is one of the following: a direct read or write of one of the two registers, a redirect to the other register, a 64-bit access to a fixed slot of the virtualization page in memory, a trap to EL2, a lock exception, or an undefined-instruction report.

The choice depends on a 3-bit nested-virtualization control value, a host-mode flag, and the guarded-stack lock qualifiers. Taking an exception into EL2 loads the hypervisor-level register with the preferred return address, and this capture wins over any write in the same cycle. The decision logic is purely combinational. Register updates happen on the rising clock edge.

Top module: `elr_access_ctrl`

## Requirements
- R1: A request is claimed only when op0=2'b11, CRn=4'b0100, CRm=4'b0000, op2=3'b001 and op1 is 3'b100 (hypervisor-level register) or 3'b000 (first-level register). Any other encoding, or req_valid low, drives every decision output low.
- R2: Any claimed request at cur_el=0 raises undef only.
- R3: At cur_el=1, for the hypervisor-level encoding, nv_ctl bit 2 and bit 0 both set redirects the access to the first-level register. Any other value with bit 0 set traps. All remaining values raise undef.
- R4: At cur_el=1, for the first-level encoding, nv_ctl=3'b011 traps. nv_ctl=3'b111 raises mem_req at mem_addr = nv_base + 0x230, with mem_wr equal to req_write. Any other value accesses the first-level register directly.
- R5: At cur_el=2, the first-level encoding reaches the hypervisor-level register when host_mode=1 and the first-level register otherwise. The hypervisor-level encoding always reaches its own register.
- R6: At cur_el=3, each encoding accesses its own register directly. Trap, lock and undef never occur at this level, whatever the control inputs.
- R7: The lock is armed when gcs_present=1, lock_en=1, halted=0 and exlock=1. An armed lock turns a write into lock_exc in these cases:
  - at EL1 on the hypervisor-level encoding with nv_ctl bit 0 set;
  - at EL1 on the first-level encoding unless nv_ctl bits 1:0 are 2'b11;
  - at EL2 on the hypervisor-level encoding;
  - at EL2 on the first-level encoding with host_mode=1.
  Reads are never locked.
- R8: Every claimed request asserts exactly one of rd_valid, reg_wr, mem_req, trap_el2, lock_exc, undef.
- R9: While trap_el2 is high, trap_ec equals 6'h18.
- R10: A read returns the selected register on rdata in the same cycle. A write takes effect at the next rising edge. A request that traps, locks, is undefined or goes to memory changes neither register.
- R11: exc_take loads exc_ret_addr into the hypervisor-level register at the rising edge. It wins over a same-cycle write to that register and does not block a same-cycle write to the first-level register.
- R12: After a synchronous active-low reset both registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 (selects register) |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cur_el | input | 2 | Current exception level 0..3 |
| nv_ctl | input | 3 | Nested-virtualization control value |
| host_mode | input | 1 | Hypervisor runs a host OS |
| gcs_present | input | 1 | Guarded-stack feature implemented |
| lock_en | input | 1 | Lock enable active |
| halted | input | 1 | Core in debug halt |
| exlock | input | 1 | Processor lock bit |
| wdata | input | 64 | Write data (also memory write data) |
| nv_base | input | 64 | Virtualization page base address |
| exc_take | input | 1 | Exception taken to EL2 this cycle |
| exc_ret_addr | input | 64 | Preferred return address |
| rd_valid | output | 1 | Read served from a register |
| rdata | output | 64 | Read data |
| reg_wr | output | 1 | Write to a register accepted |
| mem_req | output | 1 | Access turned into memory request |
| mem_wr | output | 1 | Memory request is a write |
| mem_addr | output | 64 | Memory request address |
| trap_el2 | output | 1 | Trap to EL2 |
| trap_ec | output | 6 | Trap exception class |
| lock_exc | output | 1 | Lock exception |
| undef | output | 1 | Undefined access |

## Verification
The bench presets the two registers to distinct values before every vector. Each vector then probes a different control pattern: the neighbours 3'b011, 3'b101, 3'b111 and 3'b100 of nv_ctl, host on and off, and lock armed with its exceptions. A decoder that mixed the exact-match and bit-0 rules, or that let the lock fire for 3'b011 or 3'b111 on the first-level encoding, would report the wrong single outcome. Read-back at EL3 after each write catches a redirect that lands in the wrong register, and also a trapped, locked or memory-bound write that leaks into a register. Directed cases cover capture racing a same-cycle write, lock disarmed by halt or by an absent feature, foreign encodings, and the zero state after reset.

// File: rtl/elr_pkg.sv
// Shared types and constants for the exception link register controller.
// Assumes the five-field system-register encoding and four exception levels.
package elr_pkg;
    typedef enum logic [2:0] {
        DEC_NONE  = 3'd0,
        DEC_READ  = 3'd1,
        DEC_WRITE = 3'd2,
        DEC_MEM   = 3'd3,
        DEC_TRAP  = 3'd4,
        DEC_LOCK  = 3'd5,
        DEC_UNDEF = 3'd6
    } elr_dec_e;

    localparam logic [1:0] ENC_OP0     = 2'b11;
    localparam logic [2:0] ENC_OP1_HYP = 3'b100;
    localparam logic [2:0] ENC_OP1_KRN = 3'b000;
    localparam logic [3:0] ENC_CRN     = 4'b0100;
    localparam logic [3:0] ENC_CRM     = 4'b0000;
    localparam logic [2:0] ENC_OP2     = 3'b001;
endpackage

// File: rtl/elr_lock_arm.sv
// Lock qualifier: reports whether the guarded-stack lock is armed.
// Assumes all inputs are stable during the request cycle; purely combinational.
module elr_lock_arm (
    input  logic gcs_present,
    input  logic lock_en,
    input  logic halted,
    input  logic exlock,
    output logic armed
);
    // Combine the four qualifiers into a single arm flag.
    always_comb begin
        armed = gcs_present & lock_en & ~halted & exlock;
    end
endmodule

// File: rtl/elr_decode.sv
// Request decoder: matches the encoding and picks a single outcome and a
// target register from exception level, nested-virtualization control,
// host mode and lock state. Assumes cur_el is one of four levels.
module elr_decode
    import elr_pkg::*;
#(
    parameter int NV_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [1:0]      req_op0,
    input  logic [2:0]      req_op1,
    input  logic [3:0]      req_crn,
    input  logic [3:0]      req_crm,
    input  logic [2:0]      req_op2,
    input  logic [1:0]      cur_el,
    input  logic [NV_W-1:0] nv_ctl,
    input  logic            host_mode,
    input  logic            lock_armed,
    output elr_dec_e        dec,
    output logic            tgt_hyp
);
    logic     common_ok;
    logic     hit_hyp;
    logic     hit_krn;
    elr_dec_e acc;

    // Encoding match for each of the two registers.
    always_comb begin
        common_ok = (req_op0 == ENC_OP0) && (req_crn == ENC_CRN) &&
                    (req_crm == ENC_CRM) && (req_op2 == ENC_OP2);
        hit_hyp   = common_ok && (req_op1 == ENC_OP1_HYP);
        hit_krn   = common_ok && (req_op1 == ENC_OP1_KRN);
        acc       = req_write ? DEC_WRITE : DEC_READ;
    end

    // Per-level outcome selection.
    always_comb begin
        dec     = DEC_NONE;
        tgt_hyp = 1'b0;
        if (req_valid && (hit_hyp || hit_krn)) begin
            case (cur_el)
                2'd0: dec = DEC_UNDEF;
                2'd1: begin
                    if (hit_hyp) begin
                        if (req_write && lock_armed && nv_ctl[0])
                            dec = DEC_LOCK;
                        else if (nv_ctl[2] && nv_ctl[0])
                            dec = acc;
                        else if (nv_ctl[0])
                            dec = DEC_TRAP;
                        else
                            dec = DEC_UNDEF;
                    end else begin
                        if (req_write && lock_armed && (nv_ctl[1:0] != 2'b11))
                            dec = DEC_LOCK;
                        else if (nv_ctl == 3'b011)
                            dec = DEC_TRAP;
                        else if (nv_ctl == 3'b111)
                            dec = DEC_MEM;
                        else
                            dec = acc;
                    end
                end
                2'd2: begin
                    if (hit_hyp) begin
                        if (req_write && lock_armed) dec = DEC_LOCK;
                        else begin
                            dec     = acc;
                            tgt_hyp = 1'b1;
                        end
                    end else begin
                        if (req_write && lock_armed && host_mode) dec = DEC_LOCK;
                        else begin
                            dec     = acc;
                            tgt_hyp = host_mode;
                        end
                    end
                end
                default: begin
                    dec     = acc;
                    tgt_hyp = hit_hyp;
                end
            endcase
        end
    end

    // R2: level zero never yields anything but undefined.
    a_r2_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_el == 2'd0 && dec != DEC_NONE) |-> dec == DEC_UNDEF);
    // R6: highest level is never trapped, locked or undefined.
    a_r6_el3_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_el == 2'd3) |-> (dec != DEC_TRAP && dec != DEC_LOCK && dec != DEC_UNDEF));
    // R7: reads are never locked.
    a_r7_read_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_write) |-> dec != DEC_LOCK);
endmodule

// File: rtl/elr_regs.sv
// Storage for the two link registers. Entry 0 is the first-level register,
// entry 1 the hypervisor-level one. Exception capture overrides a write to
// entry 1. Assumes at most one register write per cycle.
module elr_regs #(
    parameter int DATA_W = 64,
    parameter int N_REG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hyp,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_addr,
    output logic [DATA_W-1:0] q_krn,
    output logic [DATA_W-1:0] q_hyp
);
    logic [DATA_W-1:0] q [N_REG];

    for (genvar i = 0; i < N_REG; i++) begin : g_reg
        localparam bit IS_HYP = (i == 1);
        // Update one register: reset, capture (hypervisor entry only), or write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= '0;
            else if (IS_HYP && cap_en)
                q[i] <= cap_addr;
            else if (wr_en && (wr_hyp == IS_HYP))
                q[i] <= wr_data;
        end
    end

    assign q_krn = q[0];
    assign q_hyp = q[1];

    // R11: capture always lands in the hypervisor-level register.
    a_r11_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> q_hyp == $past(cap_addr));
    // R10: a first-level write is visible after the edge.
    a_r10_krn_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hyp) |=> q_krn == $past(wr_data));
    // R10: without write or capture the registers hold.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cap_en) |=> ($stable(q_krn) && $stable(q_hyp)));
endmodule

// File: rtl/elr_access_ctrl.sv
// Exception link register access controller (top). Decodes a system-register
// request into one outcome, drives read data or a memory request, and updates
// the two registers at the clock edge. Assumes requests last one cycle.
module elr_access_ctrl
    import elr_pkg::*;
#(
    parameter int          DATA_W   = 64,
    parameter int          NV_W     = 3,
    parameter int          EC_W     = 6,
    parameter logic [11:0] NV_SLOT  = 12'h230,
    parameter logic [5:0]  TRAP_CLS = 6'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic [1:0]        cur_el,
    input  logic [NV_W-1:0]   nv_ctl,
    input  logic              host_mode,
    input  logic              gcs_present,
    input  logic              lock_en,
    input  logic              halted,
    input  logic              exlock,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] nv_base,
    input  logic              exc_take,
    input  logic [DATA_W-1:0] exc_ret_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rdata,
    output logic              reg_wr,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_addr,
    output logic              trap_el2,
    output logic [EC_W-1:0]   trap_ec,
    output logic              lock_exc,
    output logic              undef
);
    localparam logic [DATA_W-1:0] SLOT_OFS = DATA_W'(NV_SLOT);

    logic              lock_armed;
    elr_dec_e          dec;
    logic              tgt_hyp;
    logic [DATA_W-1:0] q_krn;
    logic [DATA_W-1:0] q_hyp;

    elr_lock_arm u_lock (
        .gcs_present (gcs_present),
        .lock_en     (lock_en),
        .halted      (halted),
        .exlock      (exlock),
        .armed       (lock_armed)
    );

    elr_decode #(.NV_W(NV_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_op0    (req_op0),
        .req_op1    (req_op1),
        .req_crn    (req_crn),
        .req_crm    (req_crm),
        .req_op2    (req_op2),
        .cur_el     (cur_el),
        .nv_ctl     (nv_ctl),
        .host_mode  (host_mode),
        .lock_armed (lock_armed),
        .dec        (dec),
        .tgt_hyp    (tgt_hyp)
    );

    elr_regs #(.DATA_W(DATA_W), .N_REG(2)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dec == DEC_WRITE),
        .wr_hyp   (tgt_hyp),
        .wr_data  (wdata),
        .cap_en   (exc_take),
        .cap_addr (exc_ret_addr),
        .q_krn    (q_krn),
        .q_hyp    (q_hyp)
    );

    // Fan the decision out to one-hot outputs and their data fields.
    always_comb begin
        rd_valid = (dec == DEC_READ);
        reg_wr   = (dec == DEC_WRITE);
        mem_req  = (dec == DEC_MEM);
        trap_el2 = (dec == DEC_TRAP);
        lock_exc = (dec == DEC_LOCK);
        undef    = (dec == DEC_UNDEF);
        rdata    = rd_valid ? (tgt_hyp ? q_hyp : q_krn) : '0;
        mem_wr   = mem_req & req_write;
        mem_addr = mem_req ? (nv_base + SLOT_OFS) : '0;
        trap_ec  = trap_el2 ? EC_W'(TRAP_CLS) : '0;
    end

    // R8: at most one outcome is ever signalled.
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, reg_wr, mem_req, trap_el2, lock_exc, undef}));
    // R1: nothing is signalled without a valid request.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid) |-> ({rd_valid, reg_wr, mem_req, trap_el2, lock_exc, undef} == 6'b0));
    // R9: a trap carries the fixed exception class.
    a_r9_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
        trap_el2 |-> trap_ec == EC_W'(TRAP_CLS));
    // R4: memory requests only come from level one.
    a_r4_mem_el1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (cur_el == 2'd1 && nv_ctl == 3'b111));
endmodule

// File: tb/tb_elr_access_ctrl.sv
// Self-checking bench: a vector table walked by one loop, then directed cases.
module tb_elr_access_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_op0 = 2'b11;
    logic [2:0]  req_op1 = 3'b000;
    logic [3:0]  req_crn = 4'b0100, req_crm = 4'b0000;
    logic [2:0]  req_op2 = 3'b001;
    logic [1:0]  cur_el = 2'd3;
    logic [2:0]  nv_ctl = 3'b000;
    logic        host_mode = 1'b0, gcs_present = 1'b0, lock_en = 1'b0;
    logic        halted = 1'b0, exlock = 1'b0;
    logic [63:0] wdata = '0, nv_base = 64'h0000_0040_0000_0000;
    logic        exc_take = 1'b0;
    logic [63:0] exc_ret_addr = '0;
    logic        rd_valid, reg_wr, mem_req, mem_wr, trap_el2, lock_exc, undef;
    logic [63:0] rdata, mem_addr;
    logic [5:0]  trap_ec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [63:0] VAL_K = 64'h1111_2222_3333_4444;
    localparam logic [63:0] VAL_H = 64'h5555_6666_7777_8888;
    localparam logic [63:0] VAL_W = 64'hABCD_0123_4567_89EF;

    always #5 clk = ~clk;

    elr_access_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .cur_el(cur_el), .nv_ctl(nv_ctl), .host_mode(host_mode),
        .gcs_present(gcs_present), .lock_en(lock_en), .halted(halted), .exlock(exlock),
        .wdata(wdata), .nv_base(nv_base), .exc_take(exc_take), .exc_ret_addr(exc_ret_addr),
        .rd_valid(rd_valid), .rdata(rdata), .reg_wr(reg_wr), .mem_req(mem_req),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .trap_el2(trap_el2), .trap_ec(trap_ec),
        .lock_exc(lock_exc), .undef(undef)
    );

    // Vector: {el[2], hyp_enc, write, nv[3], host, lock_armed, exp_code[3], exp_tgt_hyp}
    // exp_code: 0 none, 1 read, 2 write, 3 mem, 4 trap, 5 lock, 6 undef.
    localparam int NV = 28;
    localparam logic [12:0] VT [NV] = '{
        {2'd0,1'b1,1'b0,3'b000,1'b0,1'b0,3'd6,1'b0}, // R2
        {2'd0,1'b0,1'b1,3'b111,1'b0,1'b0,3'd6,1'b0}, // R2
        {2'd1,1'b1,1'b0,3'b101,1'b0,1'b0,3'd1,1'b0}, // R3 redirect
        {2'd1,1'b1,1'b1,3'b111,1'b0,1'b0,3'd2,1'b0}, // R3 redirect write
        {2'd1,1'b1,1'b0,3'b001,1'b0,1'b0,3'd4,1'b0}, // R3 trap
        {2'd1,1'b1,1'b1,3'b011,1'b0,1'b0,3'd4,1'b0}, // R3 trap
        {2'd1,1'b1,1'b0,3'b100,1'b0,1'b0,3'd6,1'b0}, // R3 undef
        {2'd1,1'b1,1'b0,3'b000,1'b0,1'b0,3'd6,1'b0}, // R3 undef
        {2'd1,1'b0,1'b0,3'b011,1'b0,1'b0,3'd4,1'b0}, // R4 trap
        {2'd1,1'b0,1'b1,3'b111,1'b0,1'b0,3'd3,1'b0}, // R4 mem write
        {2'd1,1'b0,1'b0,3'b111,1'b0,1'b0,3'd3,1'b0}, // R4 mem read
        {2'd1,1'b0,1'b0,3'b101,1'b0,1'b0,3'd1,1'b0}, // R4 direct
        {2'd1,1'b0,1'b1,3'b001,1'b0,1'b0,3'd2,1'b0}, // R4 direct write
        {2'd2,1'b0,1'b0,3'b000,1'b1,1'b0,3'd1,1'b1}, // R5 host redirect
        {2'd2,1'b0,1'b1,3'b000,1'b0,1'b0,3'd2,1'b0}, // R5 no host
        {2'd2,1'b1,1'b1,3'b000,1'b0,1'b0,3'd2,1'b1}, // R5 own
        {2'd3,1'b1,1'b0,3'b011,1'b0,1'b0,3'd1,1'b1}, // R6
        {2'd3,1'b0,1'b1,3'b111,1'b0,1'b0,3'd2,1'b0}, // R6
        {2'd1,1'b1,1'b1,3'b001,1'b0,1'b1,3'd5,1'b0}, // R7 lock
        {2'd1,1'b1,1'b1,3'b100,1'b0,1'b1,3'd6,1'b0}, // R7 bit0 clear
        {2'd1,1'b0,1'b1,3'b011,1'b0,1'b1,3'd4,1'b0}, // R7 x11 exempt
        {2'd1,1'b0,1'b1,3'b111,1'b0,1'b1,3'd3,1'b0}, // R7 x11 exempt
        {2'd1,1'b0,1'b1,3'b000,1'b0,1'b1,3'd5,1'b0}, // R7 lock
        {2'd2,1'b1,1'b1,3'b000,1'b0,1'b1,3'd5,1'b0}, // R7 lock
        {2'd2,1'b0,1'b1,3'b000,1'b0,1'b1,3'd2,1'b0}, // R7 no host
        {2'd2,1'b0,1'b1,3'b000,1'b1,1'b1,3'd5,1'b0}, // R7 host lock
        {2'd3,1'b1,1'b1,3'b000,1'b0,1'b1,3'd2,1'b1}, // R6 no lock
        {2'd1,1'b0,1'b0,3'b000,1'b0,1'b1,3'd1,1'b0}  // R7 read
    };

    function automatic int code_now();
        int n;
        n = int'(rd_valid) + int'(reg_wr) + int'(mem_req) + int'(trap_el2) +
            int'(lock_exc) + int'(undef);
        if (n == 0) return 0;
        if (n > 1) return 7;
        if (rd_valid) return 1;
        if (reg_wr) return 2;
        if (mem_req) return 3;
        if (trap_el2) return 4;
        if (lock_exc) return 5;
        return 6;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request at the falling edge; outputs are valid 1 ns later.
    task automatic drive(input logic [1:0] el, input logic hyp, input logic wr,
                         input logic [2:0] nv, input logic host, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; cur_el = el; nv_ctl = nv;
        host_mode = host; wdata = d;
        req_op1 = hyp ? 3'b100 : 3'b000;
        #1;
    endtask

    task automatic finish_req();
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; exc_take = 1'b0;
    endtask

    task automatic rd_back(input logic hyp, output logic [63:0] v);
        logic sg, sl, sh, sx;
        sg = gcs_present; sl = lock_en; sh = halted; sx = exlock;
        drive(2'd3, hyp, 1'b0, 3'b000, 1'b0, '0);
        v = rdata;
        finish_req();
    endtask

    task automatic preset();
        drive(2'd3, 1'b0, 1'b1, 3'b000, 1'b0, VAL_K); finish_req();
        drive(2'd3, 1'b1, 1'b1, 3'b000, 1'b0, VAL_H); finish_req();
    endtask

    task automatic set_lock(input logic on);
        gcs_present = on; lock_en = on; exlock = on; halted = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] vk, vh;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R12: reset state.
        rd_back(1'b0, vk); check("R12 first-level reset", vk, '0);
        rd_back(1'b1, vh); check("R12 hyp reset", vh, '0);
        #1 check("R1 idle outputs", 64'(code_now()), 64'd0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            int exp_code;
            logic [63:0] exp_k, exp_h;
            v = VT[i];
            exp_code = int'(v[3:1]);
            set_lock(1'b0);
            preset();
            set_lock(v[4]);
            drive(v[12:11], v[10], v[9], v[8:6], v[5], VAL_W);
            check($sformatf("R8 vec%0d outcome", i), 64'(code_now()), 64'(exp_code));
            if (exp_code == 1)
                check($sformatf("R10 vec%0d rdata", i), rdata, v[0] ? VAL_H : VAL_K);
            if (exp_code == 3) begin
                check($sformatf("R4 vec%0d mem_addr", i), mem_addr, nv_base + 64'h230);
                check($sformatf("R4 vec%0d mem_wr", i), 64'(mem_wr), 64'(v[9]));
            end
            if (exp_code == 4)
                check($sformatf("R9 vec%0d trap_ec", i), 64'(trap_ec), 64'h18);
            finish_req();
            set_lock(1'b0);
            exp_k = (exp_code == 2 && !v[0]) ? VAL_W : VAL_K;
            exp_h = (exp_code == 2 &&  v[0]) ? VAL_W : VAL_H;
            rd_back(1'b0, vk); check($sformatf("R10 vec%0d first-level", i), vk, exp_k);
            rd_back(1'b1, vh); check($sformatf("R10 vec%0d hyp", i), vh, exp_h);
        end

        // R1: foreign encodings are not claimed.
        drive(2'd3, 1'b0, 1'b0, 3'b000, 1'b0, '0);
        req_op1 = 3'b010; #1;
        check("R1 foreign op1", 64'(code_now()), 64'd0);
        req_op1 = 3'b100; req_crm = 4'b0001; #1;
        check("R1 foreign CRm", 64'(code_now()), 64'd0);
        req_crm = 4'b0000; req_op2 = 3'b000; #1;
        check("R1 foreign op2", 64'(code_now()), 64'd0);
        req_op2 = 3'b001;
        finish_req();

        // R7: lock disarmed by halt and by absent feature.
        preset();
        set_lock(1'b1); halted = 1'b1;
        drive(2'd2, 1'b1, 1'b1, 3'b000, 1'b0, VAL_W);
        check("R7 halted no lock", 64'(code_now()), 64'd2);
        finish_req();
        set_lock(1'b1); gcs_present = 1'b0;
        drive(2'd1, 1'b0, 1'b1, 3'b000, 1'b0, VAL_W);
        check("R7 no feature no lock", 64'(code_now()), 64'd2);
        finish_req();
        set_lock(1'b0);

        // R11: capture alone, then racing a hyp write, then with a first-level write.
        preset();
        @(negedge clk); exc_take = 1'b1; exc_ret_addr = 64'h0000_0000_DEAD_BEE0;
        @(posedge clk); @(negedge clk); exc_take = 1'b0;
        rd_back(1'b1, vh); check("R11 capture", vh, 64'h0000_0000_DEAD_BEE0);
        drive(2'd3, 1'b1, 1'b1, 3'b000, 1'b0, VAL_W);
        exc_take = 1'b1; exc_ret_addr = 64'hFFFF_0000_1234_5678;
        finish_req();
        rd_back(1'b1, vh); check("R11 capture beats write", vh, 64'hFFFF_0000_1234_5678);
        drive(2'd3, 1'b0, 1'b1, 3'b000, 1'b0, VAL_W);
        exc_take = 1'b1; exc_ret_addr = 64'h0000_0000_0000_1000;
        finish_req();
        rd_back(1'b0, vk); check("R11 first-level write kept", vk, VAL_W);
        rd_back(1'b1, vh); check("R11 capture with other write", vh, 64'h0000_0000_0000_1000);

        // R12: reset again clears both.
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); @(negedge clk) rst_n = 1'b1;
        rd_back(1'b0, vk); check("R12 re-reset first-level", vk, '0);
        rd_back(1'b1, vh); check("R12 re-reset hyp", vh, '0);

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule